// File: doc/BRIEF.md
# Selective Branch Misprediction Recovery

This block decides what to discard from a circular instruction window when a branch turns out to be mispredicted. Instead of throwing away every instruction younger than the branch, it looks for the correct branch target among the younger instructions already held in the window. When that target is present, only the wrong-path instructions between the branch and the target are discarded. The target and everything after it stay in the window, and fetch resumes after the youngest instruction that was kept.

The window owner supplies the live state of every slot: a valid bit, an instruction address and the head (oldest) pointer. A resolve event carries the slot index of the branch, the correct next address, and the predicted and actual directions. One cycle later the block returns a per-slot squash mask, a flag that tells whether the target was found, and the address from which fetch must restart. The selective search is used only for branches that were predicted not-taken and turned out taken. Every other misprediction gets a conventional flush of all younger entries.

Top module: `branch_selective_flush`

## Requirements
- R1: Outputs are registered. `recover_o` is high in the cycle after a resolve event whose predicted and actual directions differ, and low in any cycle that does not follow such an event.
- R2: A resolve event with a correct prediction, or a cycle with no resolve event, gives `recover_o`=0, `target_hit_o`=0, an all-zero squash mask and `refetch_addr_o`=0 in the next cycle.
- R3: The search covers only valid entries younger than the branch, taken in age order from the head pointer. When several entries match the target, the oldest of them (the first match) is chosen.
- R4: On a hit, the squash mask marks exactly the valid entries that are younger than the branch and older than the matching entry. The matching entry and all younger entries are left unmarked.
- R5: On a miss, the squash mask marks every valid entry younger than the branch.
- R6: The search runs only when the branch was predicted not-taken (`pred_taken_i`=0) and resolved taken (`actual_taken_i`=1). Any other misprediction does a full flush as in R5 with `target_hit_o`=0.
- R7: On a hit, `refetch_addr_o` equals the address of the youngest valid entry plus INSTR_BYTES (default 4). Kept entries are never fetched again.
- R8: On a miss, `refetch_addr_o` equals the resolve target address.
- R9: The squash mask never marks the branch entry, an entry older than the branch, or an invalid entry. Invalid entries and older entries whose address equals the target never count as a hit.
- R10: The age of slot i is (i - head) modulo DEPTH, and DEPTH is a power of two. Recovery behaves the same for every head position, including windows that wrap past the last slot.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resolve_valid_i | input | 1 | A branch resolves this cycle |
| resolve_idx_i | input | IDX_W | Window slot of the resolving branch |
| resolve_target_i | input | ADDR_W | Correct next address of the branch |
| pred_taken_i | input | 1 | Predicted direction |
| actual_taken_i | input | 1 | Resolved direction |
| head_ptr_i | input | IDX_W | Slot of the oldest entry |
| entry_valid_i | input | DEPTH | Valid bit for each slot |
| entry_addr_i | input | DEPTH*ADDR_W | Instruction address for each slot, slot i in bits [i*ADDR_W +: ADDR_W] |
| recover_o | output | 1 | Recovery result valid this cycle |
| squash_o | output | DEPTH | Slots to discard, indexed by slot |
| target_hit_o | output | 1 | Correct target was found in the window |
| refetch_addr_o | output | ADDR_W | Address from which fetch restarts |

## Verification
The assertions check on every cycle that recovery follows exactly the mispredicted resolve events, one cycle later, and that the outputs stay quiet otherwise. They also check that a hit comes only from a not-taken-to-taken branch, that a miss restarts at the resolve target, and that the branch slot and invalid slots are never marked. Which slots lie between the branch and the first match, the choice of the oldest among duplicate matches, the refetch address after the youngest kept entry, and correct handling of every head position can only be shown by the bench. It sweeps all head positions, window fills, branch positions, target positions and direction pairs on a small window and computes each expected mask and address in the age domain.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_FULL   = 2'd1,
    RES_SELECT = 2'd2
  } res_mode_e;
endpackage

// File: rtl/sbf_age_map.sv
// Rotates slot-indexed window state into age order (age 0 = head).
module sbf_age_map #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]        head_i,
  input  logic [IDX_W-1:0]        br_idx_i,
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [DEPTH*ADDR_W-1:0] addr_i,
  output logic [DEPTH-1:0]        valid_age_o,
  output logic [DEPTH*ADDR_W-1:0] addr_age_o,
  output logic [IDX_W-1:0]        br_age_o
);
  assign br_age_o = br_idx_i - head_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rot
    logic [IDX_W-1:0] src;
    assign src = head_i + IDX_W'(k);
    assign valid_age_o[k] = valid_i[src];
    assign addr_age_o[k*ADDR_W +: ADDR_W] = addr_i[src*ADDR_W +: ADDR_W];
  end
endmodule

// File: rtl/sbf_target_search.sv
// First-match search for the target among valid entries younger than the branch.
module sbf_target_search #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    en_i,
  input  logic [DEPTH-1:0]        valid_age_i,
  input  logic [DEPTH*ADDR_W-1:0] addr_age_i,
  input  logic [IDX_W-1:0]        br_age_i,
  input  logic [ADDR_W-1:0]       target_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        hit_age_o,
  output logic [IDX_W-1:0]        young_age_o
);
  always_comb begin
    hit_o       = 1'b0;
    hit_age_o   = '0;
    young_age_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (valid_age_i[k]) begin
        young_age_o = IDX_W'(k);
        if (en_i && !hit_o && (IDX_W'(k) > br_age_i) &&
            (addr_age_i[k*ADDR_W +: ADDR_W] == target_i)) begin
          hit_o     = 1'b1;
          hit_age_o = IDX_W'(k);
        end
      end
    end
  end
endmodule

// File: rtl/sbf_squash_gen.sv
// Per-slot squash decision, back in slot index order.
module sbf_squash_gen #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             flush_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_age_i,
  input  logic [IDX_W-1:0] br_age_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] squash_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_sq
    logic [IDX_W-1:0] age;
    logic             younger;
    logic             wrong_path;
    assign age        = IDX_W'(i) - head_i;
    assign younger    = valid_i[i] && (age > br_age_i);
    assign wrong_path = !hit_i || (age < hit_age_i);
    assign squash_o[i] = flush_i && younger && wrong_path;
  end
endmodule

// File: rtl/branch_selective_flush.sv
module branch_selective_flush #(
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4,
  localparam int IDX_W      = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    resolve_valid_i,
  input  logic [IDX_W-1:0]        resolve_idx_i,
  input  logic [ADDR_W-1:0]       resolve_target_i,
  input  logic                    pred_taken_i,
  input  logic                    actual_taken_i,
  input  logic [IDX_W-1:0]        head_ptr_i,
  input  logic [DEPTH-1:0]        entry_valid_i,
  input  logic [DEPTH*ADDR_W-1:0] entry_addr_i,
  output logic                    recover_o,
  output logic [DEPTH-1:0]        squash_o,
  output logic                    target_hit_o,
  output logic [ADDR_W-1:0]       refetch_addr_o
);
  import sbf_pkg::*;

  res_mode_e               mode;
  logic [DEPTH-1:0]        valid_age;
  logic [DEPTH*ADDR_W-1:0] addr_age;
  logic [IDX_W-1:0]        br_age;
  logic                    hit;
  logic [IDX_W-1:0]        hit_age;
  logic [IDX_W-1:0]        young_age;
  logic [DEPTH-1:0]        squash_d;
  logic [ADDR_W-1:0]       refetch_d;

  always_comb begin
    if (!resolve_valid_i || (pred_taken_i == actual_taken_i)) mode = RES_NONE;
    else if (!pred_taken_i && actual_taken_i)                 mode = RES_SELECT;
    else                                                      mode = RES_FULL;
  end

  sbf_age_map #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_age (
    .head_i      (head_ptr_i),
    .br_idx_i    (resolve_idx_i),
    .valid_i     (entry_valid_i),
    .addr_i      (entry_addr_i),
    .valid_age_o (valid_age),
    .addr_age_o  (addr_age),
    .br_age_o    (br_age)
  );

  sbf_target_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_search (
    .en_i        (mode == RES_SELECT),
    .valid_age_i (valid_age),
    .addr_age_i  (addr_age),
    .br_age_i    (br_age),
    .target_i    (resolve_target_i),
    .hit_o       (hit),
    .hit_age_o   (hit_age),
    .young_age_o (young_age)
  );

  sbf_squash_gen #(.DEPTH(DEPTH)) u_squash (
    .flush_i   (mode != RES_NONE),
    .hit_i     (hit),
    .hit_age_i (hit_age),
    .br_age_i  (br_age),
    .head_i    (head_ptr_i),
    .valid_i   (entry_valid_i),
    .squash_o  (squash_d)
  );

  // Resume fetch past the youngest kept entry on a hit.
  always_comb begin
    if (mode == RES_NONE) refetch_d = '0;
    else if (hit)         refetch_d = addr_age[young_age*ADDR_W +: ADDR_W] + ADDR_W'(INSTR_BYTES);
    else                  refetch_d = resolve_target_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recover_o      <= 1'b0;
      squash_o       <= '0;
      target_hit_o   <= 1'b0;
      refetch_addr_o <= '0;
    end else begin
      recover_o      <= (mode != RES_NONE);
      squash_o       <= squash_d;
      target_hit_o   <= hit;
      refetch_addr_o <= refetch_d;
    end
  end
endmodule

// File: rtl/sbf_recovery_chk.sv
module sbf_recovery_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    resolve_valid_i,
  input logic [IDX_W-1:0]        resolve_idx_i,
  input logic [ADDR_W-1:0]       resolve_target_i,
  input logic                    pred_taken_i,
  input logic                    actual_taken_i,
  input logic [DEPTH-1:0]        entry_valid_i,
  input logic                    recover_o,
  input logic [DEPTH-1:0]        squash_o,
  input logic                    target_hit_o,
  input logic [ADDR_W-1:0]       refetch_addr_o
);
  p_recover_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_valid_i && (pred_taken_i != actual_taken_i)) |=> recover_o);

  p_recover_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> $past(resolve_valid_i && (pred_taken_i != actual_taken_i)));

  p_quiet_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recover_o |-> (squash_o == '0 && !target_hit_o && refetch_addr_o == '0));

  p_hit_direction_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_hit_o |-> (recover_o && $past(!pred_taken_i && actual_taken_i)));

  p_miss_refetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recover_o && !target_hit_o) |-> refetch_addr_o == $past(resolve_target_i));

  p_branch_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> !squash_o[$past(resolve_idx_i)]);

  p_valid_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o & ~$past(entry_valid_i)) == '0);

  always_comb begin
    if (!rst_ni) p_reset_quiet_r11: assert (!recover_o && squash_o == '0);
  end
endmodule

bind branch_selective_flush sbf_recovery_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .resolve_valid_i  (resolve_valid_i),
  .resolve_idx_i    (resolve_idx_i),
  .resolve_target_i (resolve_target_i),
  .pred_taken_i     (pred_taken_i),
  .actual_taken_i   (actual_taken_i),
  .entry_valid_i    (entry_valid_i),
  .recover_o        (recover_o),
  .squash_o         (squash_o),
  .target_hit_o     (target_hit_o),
  .refetch_addr_o   (refetch_addr_o)
);

// File: tb/tb_branch_selective_flush.sv
module tb_branch_selective_flush;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rv = 1'b0;
  logic [IW-1:0] ridx = '0;
  logic [AW-1:0] rtgt = '0;
  logic          pt = 1'b0;
  logic          at = 1'b0;
  logic [IW-1:0] head = '0;
  logic [D-1:0]  ev = '0;
  logic [D*AW-1:0] ea = '0;
  logic          recover;
  logic [D-1:0]  squash;
  logic          hit;
  logic [AW-1:0] refetch;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_selective_flush #(.DEPTH(D), .ADDR_W(AW), .INSTR_BYTES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .resolve_valid_i(rv), .resolve_idx_i(ridx),
    .resolve_target_i(rtgt), .pred_taken_i(pt), .actual_taken_i(at),
    .head_ptr_i(head), .entry_valid_i(ev), .entry_addr_i(ea),
    .recover_o(recover), .squash_o(squash), .target_hit_o(hit), .refetch_addr_o(refetch)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] base_addr(int k);
    return AW'(16'h1000 + k * 8);
  endfunction

  // m: target age or -1 (absent); variant 1 duplicates target at m+1, variant 2 puts it on age 0 (older)
  task automatic run_case(int h, int n, int b, int m, bit p, bit a, int variant);
    logic [AW-1:0] addr_k [D];
    logic [AW-1:0] tgt;
    logic [D-1:0]  exp_sq;
    bit            mis, sel, exp_hit;
    int            hpos;
    logic [AW-1:0] exp_ref;
    string         tag;
    for (int k = 0; k < D; k++) addr_k[k] = (k < n) ? base_addr(k) : 16'hF000;
    if (variant == 1 && m >= 0 && m + 1 < n) addr_k[m+1] = addr_k[m];
    if (m >= 0)            tgt = addr_k[m];
    else if (variant == 2) tgt = addr_k[0];
    else                   tgt = 16'hF000;
    mis = (p != a);
    sel = mis && !p && a;
    exp_hit = 1'b0;
    hpos = D;
    if (sel)
      for (int k = b + 1; k < n; k++)
        if (!exp_hit && addr_k[k] == tgt) begin exp_hit = 1'b1; hpos = k; end
    exp_sq = '0;
    for (int i = 0; i < D; i++) begin
      int k = (i - h) & (D - 1);
      if (mis && k < n && k > b && k < hpos) exp_sq[i] = 1'b1;
    end
    exp_ref = !mis ? '0 : exp_hit ? AW'(addr_k[n-1] + 4) : tgt;
    tag = !mis ? "R2" : !sel ? "R6" : exp_hit ? ((variant == 1) ? "R3" : "R4") : "R5";

    @(negedge clk);
    head = IW'(h);
    ridx = IW'(h + b);
    rtgt = tgt;
    pt = p; at = a;
    rv = 1'b1;
    for (int i = 0; i < D; i++) begin
      int k = (i - h) & (D - 1);
      ev[i] = (k < n);
      ea[i*AW +: AW] = addr_k[k];
    end
    @(negedge clk);
    rv = 1'b0;
    check({tag, " squash (R10 R9)"}, 64'(squash), 64'(exp_sq));
    check({tag, " hit/recover (R1)"}, {62'd0, recover, hit}, {62'd0, mis, exp_hit});
    check({tag, exp_hit ? " refetch R7" : " refetch R8"}, 64'(refetch), 64'(exp_ref));
    @(negedge clk);
    check("R1 R2 idle after event", {recover, squash, hit, refetch}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {recover, squash, hit, refetch}, '0);
    rst_n = 1'b1;
    for (int h = 0; h < D; h++)
      for (int n = 1; n <= D; n++)
        for (int b = 0; b < n; b++)
          for (int m = b; m < n; m++) begin
            int mm = (m == b) ? -1 : m;
            run_case(h, n, b, mm, 1'b0, 1'b1, 0);
            run_case(h, n, b, mm, 1'b1, 1'b0, 0);
            run_case(h, n, b, mm, 1'b0, 1'b0, 0);
            run_case(h, n, b, mm, 1'b1, 1'b1, 0);
            if (mm >= 0 && mm + 1 < n) run_case(h, n, b, mm, 1'b0, 1'b1, 1);
            if (mm < 0 && b > 0)       run_case(h, n, b, -1, 1'b0, 1'b1, 2);
          end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule